// File: doc/BRIEF.md
# Memory protection control register file

This block is the software-visible state of a region-based memory protection unit. A processor reaches it through a single-cycle auxiliary register port. Each request carries an address, a write flag, write data and the privilege mode of the requester. The block holds the following state:

- a read-only build word;
- an enable word that also carries the default-region permissions;
- a violation cause word;
- one base word and one permission word for each region.

The block packs and unpacks these layouts. It rejects illegal accesses with one-cycle error pulses. It drives the decoded region fields (valid, base, address mask and permissions) to the region checker that sits beside it.

The region checker reports each violation it finds through a capture strobe, and the block records it in the cause word. A machine-check event from the core turns the unit off without changing the stored enable bit. This lets software read back what was programmed.

The address map uses an 8-bit address. The control words are at 0x00 (build), 0x01 (enable) and 0x02 (cause). Region `i` has its base word at 0x10+i and its permission word at 0x20+i. Region 0 has the highest priority in the checker.

Top module: `prot_ctrl_regs`

## Requirements
- R1: A kernel read of 0x00 returns `(NUM_REGIONS << 8) | 0x03`. When the unit is built absent (`PRESENT=0`), every kernel access raises `err_instr` and returns no data.
- R2: In the enable word, bit 30 is the enable flag. Bits 8..3 are the default permissions, in the order kernel read, kernel write, kernel execute, user read, user write, user execute (bit 8 down to bit 3). All other bits read 0. `dflt_perm[5:0]` carries bits 8..3, and a write sets `unit_active` to the written bit 30.
- R3: A base word stores address bits 31..5 and uses bit 0 as the valid flag. Bits 4..1 read 0. `rgn_valid[i]` and `rgn_base[i]` (low 5 bits zero) follow the stored value.
- R4: A permission word holds a 5-bit size code: the low 2 bits are at 1..0 and the high 3 bits at 11..9. Its permission bits use the same positions as in R2. All other bits read 0, and `rgn_perm[i]` carries bits 8..3.
- R5: `rgn_mask[i]` clears the low s+1 bits for a size code s from 4 to 31, so code 31 gives a mask of 0. A code below 4 is treated as 4 (mask 0xFFFFFFE0).
- R6: An access with `user_mode` high raises `err_priv` and has no effect on any state. A read in user mode returns no data.
- R7: A region access whose index is not below `NUM_REGIONS` raises `err_instr` and has no effect. An access to an address outside the map does the same.
- R8: The cause word reads as `0x06` in bits 23..16, the violation type in bits 9..8 and the region number in bits 7..0. It is loaded from `viol_type` and `viol_region` when `viol_valid` is high.
- R9: `mchk` clears `unit_active` and leaves the stored enable bit unchanged. When an enable write falls in the same cycle, `mchk` wins for the active flag.
- R10: Read data and `rd_valid` appear in the cycle after an accepted read. `err_priv` and `err_instr` are one-cycle pulses in the cycle after the request, and the two never pulse together.
- R11: After reset the unit is inactive, all permissions are 0, every region is invalid with base 0 and size code 0, and the cause word reads 0x00060000.
- R12: Writes to the build word and the cause word are ignored without an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Register address |
| acc_wdata | input | 32 | Write data |
| user_mode | input | 1 | Requester runs in user mode |
| viol_valid | input | 1 | Checker reports a violation |
| viol_type | input | 2 | Violation type to record |
| viol_region | input | 8 | Region number to record |
| mchk | input | 1 | Machine-check event |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid pulse |
| err_priv | output | 1 | Privilege-violation pulse |
| err_instr | output | 1 | Instruction-error pulse |
| unit_active | output | 1 | Protection unit in effect |
| dflt_perm | output | 6 | Default-region permissions |
| rgn_valid | output | NUM_REGIONS | Per-region valid |
| rgn_base | output | NUM_REGIONS*32 | Per-region base address |
| rgn_mask | output | NUM_REGIONS*32 | Per-region address mask |
| rgn_perm | output | NUM_REGIONS*6 | Per-region permissions |

## Verification
The bench writes junk into the unused bits of every word and reads the words back. A design that stored those bits, or that put the two parts of the size code back together in the wrong order, would return the wrong word and drive the wrong mask.

It covers the size-code corners:

- code 2, which must act as 4;
- code 26;
- code 31, which must open the whole address space.

It also covers the index boundary: region 7 is accepted and region 8 is rejected.

It checks that a user-mode write leaves the enable and base words unchanged when they are read back from kernel mode. It checks that a machine-check pulse drops the active flag while the enable bit still reads back as set. It also checks that the pulse overrides an enable write in the same cycle; a design that let the write win would stay active.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int VERSION_ID = 3;
    localparam int CAUSE_VEC  = 6;
    localparam int EN_POS     = 30;
    localparam int PERM_LSB   = 3;
    localparam int PERM_W     = 6;
    localparam int SZ_W       = 5;
    localparam int SZ_HI_LSB  = 9;
    localparam int BASE_LSB   = 5;
    localparam int BASE_W     = 32 - BASE_LSB;
    localparam int IDX_W      = 4;
    localparam int MAX_REGIONS = 1 << IDX_W;

    localparam logic [3:0] GRP_CTL  = 4'h0;
    localparam logic [3:0] GRP_BASE = 4'h1;
    localparam logic [3:0] GRP_PERM = 4'h2;

    localparam logic [3:0] CTL_BUILD = 4'h0;
    localparam logic [3:0] CTL_EN    = 4'h1;
    localparam logic [3:0] CTL_CAUSE = 4'h2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BUILD,
        SEL_EN,
        SEL_CAUSE,
        SEL_BASE,
        SEL_PERM
    } sel_e;

    typedef struct packed {
        logic [BASE_W-1:0] addr;
        logic              valid;
        logic [SZ_W-1:0]   size;
        logic [PERM_W-1:0] perm;
    } rgn_t;

    typedef struct packed {
        logic              en;
        logic              active;
        logic [PERM_W-1:0] dperm;
        logic [1:0]        vtype;
        logic [7:0]        vregion;
        logic [31:0]       rdata;
        logic              rvalid;
        logic              eprv;
        logic              eins;
    } ctl_t;

endpackage

// File: rtl/prot_acc_decode.sv
module prot_acc_decode
    import prot_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter bit PRESENT     = 1'b1
) (
    input  logic             req,
    input  logic [7:0]       addr,
    input  logic             user_mode,
    output sel_e             sel,
    output logic [IDX_W-1:0] idx,
    output logic             priv_err,
    output logic             instr_err
);

    localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_REGIONS);

    logic [3:0] grp;
    sel_e       raw_sel;
    logic       in_range;

    always_comb begin
        grp      = addr[7:4];
        idx      = addr[IDX_W-1:0];
        in_range = ({1'b0, idx} < NUM_L);
        raw_sel  = SEL_NONE;
        case (grp)
            GRP_CTL: begin
                case (idx)
                    CTL_BUILD: raw_sel = SEL_BUILD;
                    CTL_EN:    raw_sel = SEL_EN;
                    CTL_CAUSE: raw_sel = SEL_CAUSE;
                    default:   raw_sel = SEL_NONE;
                endcase
            end
            GRP_BASE: raw_sel = in_range ? SEL_BASE : SEL_NONE;
            GRP_PERM: raw_sel = in_range ? SEL_PERM : SEL_NONE;
            default:  raw_sel = SEL_NONE;
        endcase

        sel       = SEL_NONE;
        priv_err  = 1'b0;
        instr_err = 1'b0;
        if (req) begin
            if (user_mode) begin
                priv_err = 1'b1;
            end else if (!PRESENT || raw_sel == SEL_NONE) begin
                instr_err = 1'b1;
            end else begin
                sel = raw_sel;
            end
        end
    end

endmodule

// File: rtl/prot_size_mask.sv
module prot_size_mask
    import prot_pkg::*;
(
    input  logic [SZ_W-1:0] size_code,
    output logic [31:0]     mask
);

    logic [SZ_W-1:0] eff;
    logic [31:0]     span;

    always_comb begin
        eff  = (size_code < SZ_W'(4)) ? SZ_W'(4) : size_code;
        span = (32'd2 << eff) - 32'd1;
        mask = (eff == SZ_W'(31)) ? 32'd0 : ~span;
    end

endmodule

// File: rtl/prot_ctrl_regs.sv
module prot_ctrl_regs
    import prot_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter bit PRESENT     = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_valid,
    input  logic                       acc_write,
    input  logic [7:0]                 acc_addr,
    input  logic [31:0]                acc_wdata,
    input  logic                       user_mode,
    input  logic                       viol_valid,
    input  logic [1:0]                 viol_type,
    input  logic [7:0]                 viol_region,
    input  logic                       mchk,
    output logic [31:0]                rd_data,
    output logic                       rd_valid,
    output logic                       err_priv,
    output logic                       err_instr,
    output logic                       unit_active,
    output logic [PERM_W-1:0]          dflt_perm,
    output logic [NUM_REGIONS-1:0]     rgn_valid,
    output logic [NUM_REGIONS*32-1:0]  rgn_base,
    output logic [NUM_REGIONS*32-1:0]  rgn_mask,
    output logic [NUM_REGIONS*PERM_W-1:0] rgn_perm
);

    localparam logic [7:0] BUILD_CNT = 8'(NUM_REGIONS);
    localparam logic [7:0] BUILD_VER = PRESENT ? 8'(VERSION_ID) : 8'd0;

    ctl_t ctl_d, ctl_q;
    rgn_t rgn_d [NUM_REGIONS];
    rgn_t rgn_q [NUM_REGIONS];

    sel_e             sel;
    logic [IDX_W-1:0] idx;
    logic             dec_priv;
    logic             dec_instr;
    logic [31:0]      rd_mux;
    logic             en_bit;

    prot_acc_decode #(
        .NUM_REGIONS (NUM_REGIONS),
        .PRESENT     (PRESENT)
    ) i_decode (
        .req       (acc_valid),
        .addr      (acc_addr),
        .user_mode (user_mode),
        .sel       (sel),
        .idx       (idx),
        .priv_err  (dec_priv),
        .instr_err (dec_instr)
    );

    // read multiplexer: packs the selected word
    always_comb begin
        rd_mux = 32'd0;
        case (sel)
            SEL_BUILD: rd_mux = {16'd0, BUILD_CNT, BUILD_VER};
            SEL_EN:    rd_mux = {1'b0, ctl_q.en, 21'd0, ctl_q.dperm, 3'd0};
            SEL_CAUSE: rd_mux = {8'd0, 8'(CAUSE_VEC), 6'd0, ctl_q.vtype, ctl_q.vregion};
            SEL_BASE: begin
                for (int i = 0; i < NUM_REGIONS; i++) begin
                    if (idx == IDX_W'(i)) begin
                        rd_mux = {rgn_q[i].addr, 4'd0, rgn_q[i].valid};
                    end
                end
            end
            SEL_PERM: begin
                for (int i = 0; i < NUM_REGIONS; i++) begin
                    if (idx == IDX_W'(i)) begin
                        rd_mux = {20'd0, rgn_q[i].size[4:2], rgn_q[i].perm,
                                  1'b0, rgn_q[i].size[1:0]};
                    end
                end
            end
            default: rd_mux = 32'd0;
        endcase
    end

    // next-state computation
    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        ctl_d.eprv   = dec_priv;
        ctl_d.eins   = dec_instr;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            rgn_d[i] = rgn_q[i];
        end

        if (viol_valid) begin
            ctl_d.vtype   = viol_type;
            ctl_d.vregion = viol_region;
        end

        if (acc_write) begin
            case (sel)
                SEL_EN: begin
                    ctl_d.en     = acc_wdata[EN_POS];
                    ctl_d.active = acc_wdata[EN_POS];
                    ctl_d.dperm  = acc_wdata[PERM_LSB +: PERM_W];
                end
                SEL_BASE: begin
                    for (int i = 0; i < NUM_REGIONS; i++) begin
                        if (idx == IDX_W'(i)) begin
                            rgn_d[i].addr  = acc_wdata[31:BASE_LSB];
                            rgn_d[i].valid = acc_wdata[0];
                        end
                    end
                end
                SEL_PERM: begin
                    for (int i = 0; i < NUM_REGIONS; i++) begin
                        if (idx == IDX_W'(i)) begin
                            rgn_d[i].size = {acc_wdata[SZ_HI_LSB +: 3], acc_wdata[1:0]};
                            rgn_d[i].perm = acc_wdata[PERM_LSB +: PERM_W];
                        end
                    end
                end
                default: ;
            endcase
        end else if (sel != SEL_NONE) begin
            ctl_d.rvalid = 1'b1;
            ctl_d.rdata  = rd_mux;
        end

        if (mchk) begin
            ctl_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < NUM_REGIONS; i++) begin
                rgn_q[i] <= '0;
            end
        end else begin
            ctl_q <= ctl_d;
            for (int i = 0; i < NUM_REGIONS; i++) begin
                rgn_q[i] <= rgn_d[i];
            end
        end
    end

    assign rd_data     = ctl_q.rdata;
    assign rd_valid    = ctl_q.rvalid;
    assign err_priv    = ctl_q.eprv;
    assign err_instr   = ctl_q.eins;
    assign unit_active = ctl_q.active;
    assign dflt_perm   = ctl_q.dperm;
    assign en_bit      = ctl_q.en;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        assign rgn_valid[g]               = rgn_q[g].valid;
        assign rgn_base[g*32 +: 32]       = {rgn_q[g].addr, 5'd0};
        assign rgn_perm[g*PERM_W +: PERM_W] = rgn_q[g].perm;

        prot_size_mask i_mask (
            .size_code (rgn_q[g].size),
            .mask      (rgn_mask[g*32 +: 32])
        );
    end

endmodule

// File: rtl/prot_ctrl_regs_chk.sv
module prot_ctrl_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       acc_write,
    input logic [7:0] acc_addr,
    input logic       user_mode,
    input logic       rd_valid,
    input logic       err_priv,
    input logic       err_instr,
    input logic       mchk,
    input logic       unit_active,
    input logic       en_bit
);

    // R6
    user_access_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && user_mode |=> err_priv && !rd_valid && !err_instr);

    // R10
    errors_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_priv && err_instr));

    // R10
    read_follows_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write && !user_mode));

    // R9
    mchk_deactivates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mchk |=> !unit_active);

    // R9
    mchk_keeps_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mchk && !(acc_valid && acc_write && !user_mode && acc_addr == 8'h01)
        |=> $stable(en_bit));

    // R2
    active_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_active |-> en_bit);

endmodule

bind prot_ctrl_regs prot_ctrl_regs_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .user_mode   (user_mode),
    .rd_valid    (rd_valid),
    .err_priv    (err_priv),
    .err_instr   (err_instr),
    .mchk        (mchk),
    .unit_active (unit_active),
    .en_bit      (en_bit)
);

// File: tb/test_prot_ctrl_regs.sv
module test_prot_ctrl_regs;

    localparam int NR = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, user_mode = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        viol_valid = 1'b0, mchk = 1'b0;
    logic [1:0]  viol_type = '0;
    logic [7:0]  viol_region = '0;
    logic        mchk_next = 1'b0;

    logic [31:0]      rd_data;
    logic             rd_valid, err_priv, err_instr, unit_active;
    logic [5:0]       dflt_perm;
    logic [NR-1:0]    rgn_valid;
    logic [NR*32-1:0] rgn_base, rgn_mask;
    logic [NR*6-1:0]  rgn_perm;

    logic [31:0]      a_rd_data;
    logic             a_rd_valid, a_err_priv, a_err_instr, a_unit_active;
    logic [5:0]       a_dflt_perm;
    logic [NR-1:0]    a_rgn_valid;
    logic [NR*32-1:0] a_rgn_base, a_rgn_mask;
    logic [NR*6-1:0]  a_rgn_perm;

    prot_ctrl_regs #(.NUM_REGIONS(NR), .PRESENT(1'b1)) i_prot_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .user_mode(user_mode),
        .viol_valid(viol_valid), .viol_type(viol_type), .viol_region(viol_region),
        .mchk(mchk), .rd_data(rd_data), .rd_valid(rd_valid), .err_priv(err_priv),
        .err_instr(err_instr), .unit_active(unit_active), .dflt_perm(dflt_perm),
        .rgn_valid(rgn_valid), .rgn_base(rgn_base), .rgn_mask(rgn_mask),
        .rgn_perm(rgn_perm)
    );

    prot_ctrl_regs #(.NUM_REGIONS(NR), .PRESENT(1'b0)) i_prot_ctrl_regs_absent (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .user_mode(user_mode),
        .viol_valid(viol_valid), .viol_type(viol_type), .viol_region(viol_region),
        .mchk(mchk), .rd_data(a_rd_data), .rd_valid(a_rd_valid), .err_priv(a_err_priv),
        .err_instr(a_err_instr), .unit_active(a_unit_active), .dflt_perm(a_dflt_perm),
        .rgn_valid(a_rgn_valid), .rgn_base(a_rgn_base), .rgn_mask(a_rgn_mask),
        .rgn_perm(a_rgn_perm)
    );

    typedef struct {
        logic        rv;
        logic [31:0] rd;
        logic        ep;
        logic        ei;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: compares each response against the queued expectation
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (rst_n && !done) begin
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(e.tag, "rd_valid", 32'(rd_valid), 32'(e.rv));
                chk(e.tag, "err_priv", 32'(err_priv), 32'(e.ep));
                chk(e.tag, "err_instr", 32'(err_instr), 32'(e.ei));
                if (e.rv) chk(e.tag, "rd_data", rd_data, e.rd);
            end else if (rd_valid || err_priv || err_instr) begin
                chk("R10", "stray pulse", {29'd0, rd_valid, err_priv, err_instr}, 32'd0);
            end
        end
    end

    task automatic cyc(bit w, logic [7:0] a, logic [31:0] d, bit u, exp_t e);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = w;
        acc_addr  = a;
        acc_wdata = d;
        user_mode = u;
        mchk      = mchk_next;
        q.push_back(e);
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        mchk      = 1'b0;
        mchk_next = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, bit u, bit ep, bit ei, string tag);
        exp_t e;
        e.rv = 1'b0; e.rd = '0; e.ep = ep; e.ei = ei; e.tag = tag;
        cyc(1'b1, a, d, u, e);
    endtask

    task automatic rd(logic [7:0] a, bit u, logic [31:0] x, bit ep, bit ei, string tag);
        exp_t e;
        e.rv = !(ep || ei); e.rd = x; e.ep = ep; e.ei = ei; e.tag = tag;
        cyc(1'b0, a, '0, u, e);
    endtask

    task automatic viol(logic [1:0] t, logic [7:0] r);
        @(negedge clk);
        viol_valid  = 1'b1;
        viol_type   = t;
        viol_region = r;
        @(posedge clk);
        #1;
        viol_valid = 1'b0;
    endtask

    task automatic pulse_mchk();
        @(negedge clk);
        mchk = 1'b1;
        @(posedge clk);
        #1;
        mchk = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state on the exported fields
        chk("R11", "unit_active", 32'(unit_active), 32'd0);
        chk("R11", "dflt_perm", 32'(dflt_perm), 32'd0);
        chk("R11", "rgn_valid", 32'(rgn_valid), 32'd0);
        chk("R11", "rgn_base0", rgn_base[31:0], 32'd0);
        chk("R5", "rgn_mask0 code0", rgn_mask[31:0], 32'hFFFF_FFE0);

        // R1 build word, and the absent variant
        rd(8'h00, 1'b0, 32'h0000_0803, 1'b0, 1'b0, "R1");
        chk("R1", "absent err_instr", 32'(a_err_instr), 32'd1);
        chk("R1", "absent rd_valid", 32'(a_rd_valid), 32'd0);

        // R11 reset values through the port
        rd(8'h01, 1'b0, 32'h0, 1'b0, 1'b0, "R11");
        rd(8'h10, 1'b0, 32'h0, 1'b0, 1'b0, "R11");
        rd(8'h20, 1'b0, 32'h0, 1'b0, 1'b0, "R11");
        rd(8'h02, 1'b0, 32'h0006_0000, 1'b0, 1'b0, "R11");

        // R2 enable word
        wr(8'h01, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R2");
        chk("R2", "unit_active", 32'(unit_active), 32'd1);
        chk("R2", "dflt_perm", 32'(dflt_perm), 32'h3F);
        rd(8'h01, 1'b0, 32'h4000_01F8, 1'b0, 1'b0, "R2");
        wr(8'h01, 32'h0000_0128, 1'b0, 1'b0, 1'b0, "R2");
        chk("R2", "unit_active off", 32'(unit_active), 32'd0);
        chk("R2", "dflt_perm order", 32'(dflt_perm), 32'h25);
        rd(8'h01, 1'b0, 32'h0000_0128, 1'b0, 1'b0, "R2");
        wr(8'h01, 32'h4000_0000, 1'b0, 1'b0, 1'b0, "R2");

        // R3 base words
        wr(8'h12, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, "R3");
        chk("R3", "rgn_valid2", 32'(rgn_valid[2]), 32'd1);
        chk("R3", "rgn_base2", rgn_base[2*32 +: 32], 32'hDEAD_BEE0);
        rd(8'h12, 1'b0, 32'hDEAD_BEE1, 1'b0, 1'b0, "R3");
        wr(8'h12, 32'h0000_1000, 1'b0, 1'b0, 1'b0, "R3");
        chk("R3", "rgn_valid2 clr", 32'(rgn_valid[2]), 32'd0);

        // R4 and R5 permission words and masks
        wr(8'h22, 32'h0010_0BFE, 1'b0, 1'b0, 1'b0, "R4");
        chk("R4", "rgn_perm2", 32'(rgn_perm[2*6 +: 6]), 32'h3F);
        chk("R5", "mask code22", rgn_mask[2*32 +: 32], 32'hFF80_0000);
        rd(8'h22, 1'b0, 32'h0000_0BFA, 1'b0, 1'b0, "R4");
        wr(8'h23, 32'h0000_0E03, 1'b0, 1'b0, 1'b0, "R5");
        chk("R5", "mask code31", rgn_mask[3*32 +: 32], 32'h0);
        wr(8'h24, 32'h0000_0202, 1'b0, 1'b0, 1'b0, "R5");
        chk("R5", "mask code6", rgn_mask[4*32 +: 32], 32'hFFFF_FF80);
        wr(8'h25, 32'h0000_0002, 1'b0, 1'b0, 1'b0, "R5");
        chk("R5", "mask code2", rgn_mask[5*32 +: 32], 32'hFFFF_FFE0);
        wr(8'h26, 32'h0000_0C02, 1'b0, 1'b0, 1'b0, "R5");
        chk("R5", "mask code26", rgn_mask[6*32 +: 32], 32'hF800_0000);

        // R7 last legal region, then out of range and unmapped
        wr(8'h17, 32'h8000_0001, 1'b0, 1'b0, 1'b0, "R7");
        rd(8'h17, 1'b0, 32'h8000_0001, 1'b0, 1'b0, "R7");
        rd(8'h18, 1'b0, 32'h0, 1'b0, 1'b1, "R7");
        wr(8'h2F, 32'h0000_0FFF, 1'b0, 1'b0, 1'b1, "R7");
        rd(8'h05, 1'b0, 32'h0, 1'b0, 1'b1, "R7");
        rd(8'h30, 1'b0, 32'h0, 1'b0, 1'b1, "R7");
        rd(8'h2F, 1'b0, 32'h0, 1'b0, 1'b1, "R7");

        // R6 user mode accesses
        wr(8'h01, 32'h0, 1'b1, 1'b1, 1'b0, "R6");
        chk("R6", "unit_active kept", 32'(unit_active), 32'd1);
        rd(8'h01, 1'b0, 32'h4000_0000, 1'b0, 1'b0, "R6");
        rd(8'h12, 1'b1, 32'h0, 1'b1, 1'b0, "R6");
        wr(8'h12, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, "R6");
        rd(8'h12, 1'b0, 32'h0000_1000, 1'b0, 1'b0, "R6");

        // R12 read-only words
        wr(8'h00, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0, "R12");
        rd(8'h00, 1'b0, 32'h0000_0803, 1'b0, 1'b0, "R12");
        wr(8'h02, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R12");
        rd(8'h02, 1'b0, 32'h0006_0000, 1'b0, 1'b0, "R12");

        // R8 cause capture
        viol(2'd2, 8'd5);
        rd(8'h02, 1'b0, 32'h0006_0205, 1'b0, 1'b0, "R8");
        viol(2'd3, 8'hFF);
        rd(8'h02, 1'b0, 32'h0006_03FF, 1'b0, 1'b0, "R8");

        // R9 machine check
        pulse_mchk();
        chk("R9", "unit_active after mchk", 32'(unit_active), 32'd0);
        rd(8'h01, 1'b0, 32'h4000_0000, 1'b0, 1'b0, "R9");
        wr(8'h01, 32'h4000_0000, 1'b0, 1'b0, 1'b0, "R9");
        chk("R9", "unit_active rearmed", 32'(unit_active), 32'd1);
        mchk_next = 1'b1;
        wr(8'h01, 32'h4000_0008, 1'b0, 1'b0, 1'b0, "R9");
        chk("R9", "mchk wins", 32'(unit_active), 32'd0);
        rd(8'h01, 1'b0, 32'h4000_0008, 1'b0, 1'b0, "R9");

        // R10 back-to-back reads
        rd(8'h17, 1'b0, 32'h8000_0001, 1'b0, 1'b0, "R10");
        rd(8'h22, 1'b0, 32'h0000_0BFA, 1'b0, 1'b0, "R10");
        repeat (3) @(posedge clk);
        #1;
        finish_run();
    end

endmodule